// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block is a multi-cycle sequencer that moves bytes between a memory byte port and an I/O byte port, one byte per step, in the way an 8-bit processor's block input and block output instructions do. Software-visible state is loaded with a single start strobe: an 8-bit count register B, an 8-bit register C that is never changed, a 16-bit memory pointer HL and the incoming carry flag. Three control bits choose the transfer mode (port to memory or memory to port), the pointer direction (up or down) and whether the operation repeats.

On every step the port is addressed by the whole 16-bit BC pair as it stands before the step. HL moves by one and only B counts down. After each step a flag byte is computed from the new B. Input mode and output mode use different flag rules. The repeating form keeps stepping until B reaches zero. A nominal cycle cost is also kept, the way an instruction-level timing model counts it: 12 for each step, plus 5 for each step that is followed by another.

The sequencer waits for the port's ready signal before it completes any port transfer. It reports completion with a one-clock done pulse, and at that moment the final register and flag values are already on its outputs.

Top module: `blkio_sequencer`

## Requirements
- R1: A synchronous active-high reset, also applied in the middle of an operation, leaves the block idle: busy, done and all four strobes low, and b_out, hl_out, flags_out and nominal_cycles zero.
- R2: In input mode (op_out=0) each step raises io_rd with io_addr = {B,C}, using B before its decrement, waits for io_ready, and then writes the received byte to memory at HL with one mem_wr cycle.
- R3: In output mode (op_out=1) each step raises mem_rd for one cycle at HL, takes mem_rdata in the following cycle, and then drives that byte on io_wdata with io_wr and io_addr = {B,C}, using B before its decrement, until io_ready.
- R4: Each step adds 1 to HL when op_dec=0 and subtracts 1 when op_dec=1, modulo 2^16. It subtracts 1 from B modulo 256 and leaves C unchanged.
- R5: The flag byte is laid out as S=bit7, Z=bit6, bit5, H=bit4, bit3, PV=bit2, N=bit1, C=bit0. In input mode, with B the new count: S, bit5 and bit3 are copied from B; Z=1 when B==0; H=0; N=1; C=0. PV is (1 when B has an even number of ones) XOR bit 2 of C, further XORed with 1 when op_dec=1.
- R6: In output mode, with B the new count: S, bit5 and bit3 are copied from B; Z=1 when B==0; H=1; N=1; PV=0; C equals carry_in as captured at start.
- R7: With op_rep=0 exactly one step is made. With op_rep=1 stepping continues while the new B is nonzero, so a start count of 0 wraps and gives 256 steps ending with B=0.
- R8: nominal_cycles is cleared at start and ends at 12 per step plus 5 per repeated continuation, which is 17*n-5 for n steps.
- R9: A port strobe and its address stay asserted until io_ready, and every step completes exactly one port transfer and one memory access, whatever the number of wait cycles.
- R10: done is high for exactly one clock, in the first idle cycle after the last step, with busy low and the final values on the outputs.
- R11: A start pulse while busy is high is ignored: the running operation finishes with the results of its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when idle |
| op_out | input | 1 | 1 = memory to port, 0 = port to memory |
| op_dec | input | 1 | 1 = HL counts down, 0 = HL counts up |
| op_rep | input | 1 | 1 = repeat until B is zero |
| b_in | input | 8 | Initial count B |
| c_in | input | 8 | Port address low byte C |
| hl_in | input | 16 | Initial memory pointer |
| carry_in | input | 1 | Carry flag before the operation |
| mem_addr | output | 16 | Memory address (HL) |
| mem_rd | output | 1 | Memory read strobe, data valid the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| io_addr | output | 16 | Port address (BC) |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, taken when io_ready is high |
| io_ready | input | 1 | Port transfer completes in this cycle |
| b_out | output | 8 | Current B |
| hl_out | output | 16 | Current HL |
| flags_out | output | 8 | Flag byte after the last step |
| nominal_cycles | output | 16 | Nominal cycle cost of the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the wrap cases. A start count of zero with repeat must give 256 transfers; a design that tests B before decrementing it would stop at once or never stop. HL crossing page and 16-bit boundaries in both directions exposes an 8-bit carry or a wrong sign. Flag cases that set Z, flip PV through bit 2 of C and the down direction, or carry a set carry_in, catch swapped input and output rules and a lost or invented carry. Port waits of up to three cycles, a start pulse in mid-run and a reset in mid-run show whether a design drops or repeats transfers, lets a second start corrupt the running state, or leaves stale outputs.

// File: rtl/blkio_pkg.sv
package blkio_pkg;

    localparam int REG_W = 8;
    localparam int PTR_W = 16;

    // flag byte bit positions
    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_Y  = 5;
    localparam int FLG_H  = 4;
    localparam int FLG_X  = 3;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;
    localparam int FLG_C  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IO_RD,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_MEM_LAT,
        ST_IO_WR,
        ST_STEP
    } seq_state_e;

    typedef struct packed {
        logic to_port;
        logic backward;
        logic again;
    } op_cfg_t;

    function automatic logic even_ones(input logic [REG_W-1:0] v);
        return ~^v;
    endfunction

    // flag byte produced after one step, from the decremented count
    function automatic logic [7:0] step_flags(input op_cfg_t cfg,
                                              input logic [REG_W-1:0] cnt,
                                              input logic c_bit2,
                                              input logic carry);
        logic [7:0] f;
        f         = '0;
        f[FLG_S]  = cnt[7];
        f[FLG_Z]  = (cnt == '0);
        f[FLG_Y]  = cnt[5];
        f[FLG_X]  = cnt[3];
        f[FLG_N]  = 1'b1;
        if (cfg.to_port) begin
            f[FLG_H] = 1'b1;
            f[FLG_C] = carry;
        end else begin
            f[FLG_PV] = even_ones(cnt) ^ c_bit2 ^ cfg.backward;
        end
        return f;
    endfunction

endpackage

// File: rtl/blkio_ptr_regs.sv
module blkio_ptr_regs
    import blkio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  op_cfg_t             cfg_in,
    input  logic [REG_W-1:0]    b_in,
    input  logic [REG_W-1:0]    c_in,
    input  logic [PTR_W-1:0]    hl_in,
    input  logic                carry_in,
    input  logic                step_en,
    input  logic                cap_io,
    input  logic [REG_W-1:0]    io_rdata,
    input  logic                cap_mem,
    input  logic [REG_W-1:0]    mem_rdata,
    output op_cfg_t             cfg_q,
    output logic [REG_W-1:0]    b_q,
    output logic [REG_W-1:0]    c_q,
    output logic [PTR_W-1:0]    hl_q,
    output logic [REG_W-1:0]    data_q,
    output logic [7:0]          flags_q,
    output logic                last_step
);

    logic             carry_q;
    logic [REG_W-1:0] b_next;
    logic [PTR_W-1:0] hl_next;

    assign b_next    = b_q - REG_W'(1);
    assign last_step = (b_next == '0);
    assign hl_next   = cfg_q.backward ? (hl_q - PTR_W'(1)) : (hl_q + PTR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            b_q     <= '0;
            c_q     <= '0;
            hl_q    <= '0;
            data_q  <= '0;
            flags_q <= '0;
            carry_q <= 1'b0;
        end else if (load_en) begin
            cfg_q   <= cfg_in;
            b_q     <= b_in;
            c_q     <= c_in;
            hl_q    <= hl_in;
            carry_q <= carry_in;
        end else begin
            if (cap_io)
                data_q <= io_rdata;
            if (cap_mem)
                data_q <= mem_rdata;
            if (step_en) begin
                b_q     <= b_next;
                hl_q    <= hl_next;
                flags_q <= step_flags(cfg_q, b_next, c_q[2], carry_q);
            end
        end
    end

    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        step_en |=> b_q == $past(b_q) - REG_W'(1));

    a_r4_hl_up: assert property (@(posedge clk) disable iff (rst)
        (step_en && !cfg_q.backward) |=> hl_q == $past(hl_q) + PTR_W'(1));

    a_r4_hl_down: assert property (@(posedge clk) disable iff (rst)
        (step_en && cfg_q.backward) |=> hl_q == $past(hl_q) - PTR_W'(1));

    a_r11_frozen_setup: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ($stable(c_q) && $stable(cfg_q)));

endmodule

// File: rtl/blkio_seq_ctrl.sv
module blkio_seq_ctrl
    import blkio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_to_port,
    input  logic q_to_port,
    input  logic q_again,
    input  logic io_ready,
    input  logic last_step,
    output logic load_en,
    output logic step_en,
    output logic repeat_go,
    output logic cap_io,
    output logic cap_mem,
    output logic io_rd,
    output logic io_wr,
    output logic mem_rd,
    output logic mem_wr,
    output logic busy,
    output logic done
);

    seq_state_e state_q, state_d;

    assign load_en   = (state_q == ST_IDLE) && start;
    assign step_en   = (state_q == ST_STEP);
    assign repeat_go = step_en && q_again && !last_step;
    assign io_rd     = (state_q == ST_IO_RD);
    assign io_wr     = (state_q == ST_IO_WR);
    assign mem_rd    = (state_q == ST_MEM_RD);
    assign mem_wr    = (state_q == ST_MEM_WR);
    assign cap_io    = io_rd && io_ready;
    assign cap_mem   = (state_q == ST_MEM_LAT);
    assign busy      = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = start_to_port ? ST_MEM_RD : ST_IO_RD;
            ST_IO_RD:   if (io_ready) state_d = ST_MEM_WR;
            ST_MEM_WR:  state_d = ST_STEP;
            ST_MEM_RD:  state_d = ST_MEM_LAT;
            ST_MEM_LAT: state_d = ST_IO_WR;
            ST_IO_WR:   if (io_ready) state_d = ST_STEP;
            ST_STEP: begin
                if (repeat_go) state_d = q_to_port ? ST_MEM_RD : ST_IO_RD;
                else           state_d = ST_IDLE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= step_en && !repeat_go;
        end
    end

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_rd, io_wr, mem_rd, mem_wr}));

    a_r9_rd_held: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_ready) |=> io_rd);

    a_r9_wr_held: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !io_ready) |=> io_wr);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r3_read_then_latch: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> cap_mem);

endmodule

// File: rtl/blkio_cost_meter.sv
module blkio_cost_meter #(
    parameter int COST_W      = 16,
    parameter int STEP_COST   = 12,
    parameter int REPEAT_COST = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              step_en,
    input  logic              repeat_go,
    output logic [COST_W-1:0] cost_q
);

    localparam logic [COST_W-1:0] STEP_INC = COST_W'(STEP_COST);
    localparam logic [COST_W-1:0] LOOP_INC = COST_W'(STEP_COST + REPEAT_COST);

    always_ff @(posedge clk) begin
        if (rst)
            cost_q <= '0;
        else if (load_en)
            cost_q <= '0;
        else if (step_en)
            cost_q <= cost_q + (repeat_go ? LOOP_INC : STEP_INC);
    end

    a_r8_cleared_at_start: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cost_q == '0);

    a_r8_loop_charge: assert property (@(posedge clk) disable iff (rst)
        (step_en && repeat_go) |=> cost_q == $past(cost_q) + COST_W'(STEP_COST + REPEAT_COST));

endmodule

// File: rtl/blkio_sequencer.sv
module blkio_sequencer
    import blkio_pkg::*;
#(
    parameter int COST_W      = 16,
    parameter int STEP_COST   = 12,
    parameter int REPEAT_COST = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_out,
    input  logic              op_dec,
    input  logic              op_rep,
    input  logic [7:0]        b_in,
    input  logic [7:0]        c_in,
    input  logic [15:0]       hl_in,
    input  logic              carry_in,
    output logic [15:0]       mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [15:0]       io_addr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [7:0]        io_wdata,
    input  logic [7:0]        io_rdata,
    input  logic              io_ready,
    output logic [7:0]        b_out,
    output logic [15:0]       hl_out,
    output logic [7:0]        flags_out,
    output logic [COST_W-1:0] nominal_cycles,
    output logic              busy,
    output logic              done
);

    op_cfg_t          cfg_in, cfg_q;
    logic             load_en, step_en, repeat_go, cap_io, cap_mem, last_step;
    logic [REG_W-1:0] b_q, c_q, data_q;
    logic [PTR_W-1:0] hl_q;

    assign cfg_in = '{to_port: op_out, backward: op_dec, again: op_rep};

    blkio_seq_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .start_to_port (op_out),
        .q_to_port     (cfg_q.to_port),
        .q_again       (cfg_q.again),
        .io_ready      (io_ready),
        .last_step     (last_step),
        .load_en       (load_en),
        .step_en       (step_en),
        .repeat_go     (repeat_go),
        .cap_io        (cap_io),
        .cap_mem       (cap_mem),
        .io_rd         (io_rd),
        .io_wr         (io_wr),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .busy          (busy),
        .done          (done)
    );

    blkio_ptr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .cfg_in    (cfg_in),
        .b_in      (b_in),
        .c_in      (c_in),
        .hl_in     (hl_in),
        .carry_in  (carry_in),
        .step_en   (step_en),
        .cap_io    (cap_io),
        .io_rdata  (io_rdata),
        .cap_mem   (cap_mem),
        .mem_rdata (mem_rdata),
        .cfg_q     (cfg_q),
        .b_q       (b_q),
        .c_q       (c_q),
        .hl_q      (hl_q),
        .data_q    (data_q),
        .flags_q   (flags_out),
        .last_step (last_step)
    );

    blkio_cost_meter #(
        .COST_W      (COST_W),
        .STEP_COST   (STEP_COST),
        .REPEAT_COST (REPEAT_COST)
    ) u_cost (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .step_en   (step_en),
        .repeat_go (repeat_go),
        .cost_q    (nominal_cycles)
    );

    assign mem_addr  = hl_q;
    assign mem_wdata = data_q;
    assign io_addr   = {b_q, c_q};
    assign io_wdata  = data_q;
    assign b_out     = b_q;
    assign hl_out    = hl_q;

endmodule

// File: tb/blkio_sequencer_test.sv
module blkio_sequencer_test;

    typedef struct packed {
        logic        to_port;
        logic        backward;
        logic        again;
        logic [7:0]  b;
        logic [7:0]  c;
        logic [15:0] hl;
        logic        cy;
        logic [1:0]  wait_n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'h05, 8'h34, 16'h1000, 1'b0, 2'd0},
        '{1'b0, 1'b1, 1'b0, 8'h01, 8'h04, 16'h2000, 1'b1, 2'd2},
        '{1'b1, 1'b0, 1'b0, 8'h80, 8'h10, 16'h3000, 1'b1, 2'd1},
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 16'h0000, 1'b0, 2'd0},
        '{1'b0, 1'b0, 1'b1, 8'h04, 8'hFF, 16'h10FE, 1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b1, 8'h03, 8'h22, 16'h4001, 1'b1, 2'd0},
        '{1'b0, 1'b1, 1'b1, 8'h02, 8'h00, 16'h0001, 1'b1, 2'd3},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h55, 16'h5000, 1'b0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, op_out = 1'b0, op_dec = 1'b0, op_rep = 1'b0;
    logic [7:0]  b_in = '0, c_in = '0;
    logic [15:0] hl_in = '0;
    logic        carry_in = 1'b0;
    logic [15:0] mem_addr, io_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, io_ready, busy, done;
    logic [7:0]  mem_wdata, io_wdata, io_rdata, b_out, flags_out;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] hl_out, nominal_cycles;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    blkio_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .op_out(op_out), .op_dec(op_dec),
        .op_rep(op_rep), .b_in(b_in), .c_in(c_in), .hl_in(hl_in), .carry_in(carry_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
        .b_out(b_out), .hl_out(hl_out), .flags_out(flags_out),
        .nominal_cycles(nominal_cycles), .busy(busy), .done(done)
    );

    // memory and port models: contents are fixed functions of the address
    function automatic logic [7:0] mem_pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] io_pat(input logic [15:0] a);
        return (a[15:8] + a[15:8] + a[15:8]) ^ a[7:0] ^ 8'hA5;
    endfunction

    always @(posedge clk) mem_rdata <= mem_pat(mem_addr);
    assign io_rdata = io_pat(io_addr);

    logic [1:0] cur_wait = 2'd0;
    logic [2:0] wcnt = '0;
    assign io_ready = (io_rd || io_wr) && (wcnt >= {1'b0, cur_wait});
    always @(posedge clk) begin
        if (io_ready || !(io_rd || io_wr)) wcnt <= '0;
        else                               wcnt <= wcnt + 3'd1;
    end

    // transfer logs
    logic        log_clr = 1'b0;
    int          io_n = 0, mem_n = 0;
    logic [15:0] lio_addr [0:299];
    logic [7:0]  lio_data [0:299];
    logic [15:0] lmem_addr[0:299];
    logic [7:0]  lmem_data[0:299];
    always @(posedge clk) begin
        if (log_clr) begin
            io_n  <= 0;
            mem_n <= 0;
        end else begin
            if ((io_rd || io_wr) && io_ready && io_n < 300) begin
                lio_addr[io_n] <= io_addr;
                lio_data[io_n] <= io_wr ? io_wdata : io_rdata;
                io_n <= io_n + 1;
            end
            if ((mem_rd || mem_wr) && mem_n < 300) begin
                lmem_addr[mem_n] <= mem_addr;
                lmem_data[mem_n] <= mem_wdata;
                mem_n <= mem_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_flags(input vec_t v, input logic [7:0] bf);
        logic even;
        even = ((bf[0] + bf[1] + bf[2] + bf[3] + bf[4] + bf[5] + bf[6] + bf[7]) % 2) == 0;
        if (v.to_port)
            return {bf[7], bf == 8'h00, bf[5], 1'b1, bf[3], 1'b0, 1'b1, v.cy};
        else
            return {bf[7], bf == 8'h00, bf[5], 1'b0, bf[3], even ^ v.c[2] ^ v.backward, 1'b1, 1'b0};
    endfunction

    task automatic run_vec(input vec_t v, input int idx, input bit disturb);
        int n, cyc, bad;
        logic [7:0]  b_e;
        logic [15:0] hl_e;
        logic [31:0] bad_act, bad_exp;
        n    = v.again ? ((v.b == 8'h00) ? 256 : int'(v.b)) : 1;
        b_e  = v.b - 8'(n);
        hl_e = v.backward ? (v.hl - 16'(n)) : (v.hl + 16'(n));
        cur_wait = v.wait_n;
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        op_out = v.to_port; op_dec = v.backward; op_rep = v.again;
        b_in = v.b; c_in = v.c; hl_in = v.hl; carry_in = v.cy;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            repeat (4) @(negedge clk);
            op_out = ~v.to_port; op_dec = ~v.backward; b_in = 8'h99;
            c_in = 8'hEE; hl_in = 16'hABCD; carry_in = ~v.cy;
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            chk(1'b0, $sformatf("R10 vector %0d no done", idx), 32'(done), 32'd1);
            return;
        end
        chk(!busy, $sformatf("R10 vector %0d busy at done", idx), 32'(busy), 32'd0);
        chk(b_out == b_e, $sformatf("R4 R7 R11 vector %0d b_out", idx), 32'(b_out), 32'(b_e));
        chk(hl_out == hl_e, $sformatf("R4 R11 vector %0d hl_out", idx), 32'(hl_out), 32'(hl_e));
        chk(flags_out == model_flags(v, b_e),
            $sformatf("%s vector %0d flags", v.to_port ? "R6" : "R5", idx),
            32'(flags_out), 32'(model_flags(v, b_e)));
        chk(nominal_cycles == 16'(17 * n - 5), $sformatf("R8 vector %0d cost", idx),
            32'(nominal_cycles), 32'(17 * n - 5));
        chk(io_n == n && mem_n == n, $sformatf("R7 R9 vector %0d transfer count io/mem", idx),
            32'((io_n << 16) | mem_n), 32'((n << 16) | n));
        bad = 0; bad_act = '0; bad_exp = '0;
        for (int k = 0; k < n && k < 300; k++) begin
            logic [7:0]  bk;
            logic [15:0] hk;
            logic [7:0]  dk;
            bk = v.b - 8'(k);
            hk = v.backward ? (v.hl - 16'(k)) : (v.hl + 16'(k));
            dk = v.to_port ? mem_pat(hk) : io_pat({bk, v.c});
            if (lio_addr[k] != {bk, v.c}) begin
                if (bad == 0) begin bad_act = 32'(lio_addr[k]); bad_exp = 32'({bk, v.c}); end
                bad++;
            end
            if (lmem_addr[k] != hk) begin
                if (bad == 0) begin bad_act = 32'(lmem_addr[k]); bad_exp = 32'(hk); end
                bad++;
            end
            if ((v.to_port ? lio_data[k] : lmem_data[k]) != dk) begin
                if (bad == 0) begin
                    bad_act = 32'(v.to_port ? lio_data[k] : lmem_data[k]);
                    bad_exp = 32'(dk);
                end
                bad++;
            end
        end
        chk(bad == 0, $sformatf("%s vector %0d transfer addresses/data", v.to_port ? "R3" : "R2", idx),
            bad_act, bad_exp);
        @(negedge clk);
        chk(!done, $sformatf("R10 vector %0d done longer than one cycle", idx), 32'(done), 32'd0);
    endtask

    task automatic check_idle(input string what);
        chk(!busy && !done, {what, " busy/done"}, 32'({busy, done}), 32'd0);
        chk(!io_rd && !io_wr && !mem_rd && !mem_wr, {what, " strobes"},
            32'({io_rd, io_wr, mem_rd, mem_wr}), 32'd0);
        chk(b_out == 8'h00 && hl_out == 16'h0000, {what, " b/hl"}, 32'({b_out, hl_out}), 32'd0);
        chk(flags_out == 8'h00 && nominal_cycles == 16'h0000, {what, " flags/cost"},
            32'({flags_out, nominal_cycles}), 32'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");

        // table walk
        for (int i = 0; i < NV; i++)
            run_vec(VECS[i], i, 1'b0);

        // R11: a second start in mid-run is ignored
        run_vec('{1'b1, 1'b0, 1'b1, 8'h06, 8'h81, 16'h7FFE, 1'b1, 2'd1}, 100, 1'b1);

        // R1: reset in the middle of a long repeat
        cur_wait = 2'd0;
        op_out = 1'b0; op_dec = 1'b0; op_rep = 1'b1;
        b_in = 8'h40; c_in = 8'h12; hl_in = 16'h6000; carry_in = 1'b1;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy, "R1 run in progress before reset", 32'(busy), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R1 mid-run reset");
        repeat (3) @(negedge clk);
        chk(!busy && !io_rd && !mem_wr, "R1 stays idle after reset",
            32'({busy, io_rd, mem_wr}), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule